// File: doc/BRIEF.md
# Operand Addressing-Mode Cycle Sequencer

This block walks through the bus cycles of a single two-operand instruction. A start strobe, taken while the block is idle, latches a source addressing-mode code and a destination addressing-mode code. From the next clock on, the block emits one phase code per cycle: the opcode-word fetch first, then the source operand work, then the destination operand work. How many phases appear depends on the two modes, through fixed additive rules. A done pulse marks the final phase.

As the sequence runs, a datapath counts the cycles it spends and the words it fetches. From the cycle after done, the block shows the total cycle count and the instruction length in words, and it holds them until the next accepted start. A start strobe that arrives while a sequence is in progress has no effect. Memory traffic and arithmetic belong to the surrounding core. The core steps its fetch and operand logic from the phase code and sizes its program-counter advance from the word total.

Top module: `opnd_seq_top`

## Requirements
- R1: After reset the phase output is idle (code 0), busy and done are low, and both counts read zero.
- R2: When start is high at a rising edge while busy is low, the modes present at that edge are captured, and the next cycle shows the fetch phase (code 1) with busy high. Later changes on the mode inputs do not alter the running sequence.
- R3: Source codes decide the source phases. Code 0 (register) and code 7 (reserved) add none. Codes 1 (indirect) and 2 (indirect auto-increment) add one source-read phase (code 3). Code 3 (immediate) adds one source-extension phase (code 2). Codes 4 (indexed), 5 (symbolic) and 6 (absolute) add a source-extension phase followed by a source-read phase.
- R4: Destination codes decide the destination phases. Code 0 (register) adds none. Code 1 (indirect) adds one write-back phase (code 6). Codes 2 (indexed) and 3 (absolute/symbolic) add destination-extension (code 4), destination-read (code 5) and write-back (code 6), in that order.
- R5: Phases are emitted one per clock: fetch, then the source phases, then the destination phases. After the last phase the block returns to idle.
- R6: done is high in exactly one cycle per sequence, the cycle of its last phase.
- R7: cycleCount equals the number of phases emitted. It is valid from the cycle after done and holds until the next accepted start.
- R8: wordCount equals 1, plus 1 when the source code is 3 to 6, plus 1 when the destination code is 2 or 3.
- R9: A start strobe during a busy cycle, including the done cycle, is ignored. The running sequence and its totals are unchanged, and no new sequence follows.
- R10: Register to register gives 1 cycle and 1 word. Register to indirect gives 2 and 1. Register to indexed gives 4 and 2. Immediate to indexed gives 5 and 3. Absolute to absolute gives 6 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence; taken only while idle |
| srcMode | input | 3 | Source addressing-mode code |
| dstMode | input | 2 | Destination addressing-mode code |
| busy | output | 1 | A sequence is in progress |
| phase | output | 3 | Current bus phase code |
| done | output | 1 | High during the final phase |
| cycleCount | output | CNT_W | Cycles used by the last sequence |
| wordCount | output | LEN_W | Instruction length in words |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a long sequence, or in its done cycle. From the outside that strobe looks exactly like a fresh request, and a faulty guard would restart the fetch or leave a spurious sequence behind. The bench runs the six-cycle absolute-to-absolute sequence and drives a one-cycle start, with different mode codes, at a chosen phase index. It then checks that the phase trail, the totals and the following idle cycles all match a sequence with no interruption. Every pairing of the eight source codes and four destination codes is also swept, and the mode inputs are scrambled right after each start to show that the modes were captured.

// File: rtl/opnd_seq_pkg.sv
package opnd_seq_pkg;

  localparam int SRC_MODE_W = 3;
  localparam int DST_MODE_W = 2;
  localparam int MAX_CYCLES = 6;
  localparam int MAX_WORDS  = 3;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_FETCH      = 3'd1,
    PH_SRC_EXT    = 3'd2,
    PH_SRC_READ   = 3'd3,
    PH_DST_EXT    = 3'd4,
    PH_DST_READ   = 3'd5,
    PH_WRITE_BACK = 3'd6
  } phase_e;

  // source codes
  localparam logic [SRC_MODE_W-1:0] SRC_REG    = 3'd0;
  localparam logic [SRC_MODE_W-1:0] SRC_IND    = 3'd1;
  localparam logic [SRC_MODE_W-1:0] SRC_INDINC = 3'd2;
  localparam logic [SRC_MODE_W-1:0] SRC_IMM    = 3'd3;
  localparam logic [SRC_MODE_W-1:0] SRC_IDX    = 3'd4;
  localparam logic [SRC_MODE_W-1:0] SRC_SYM    = 3'd5;
  localparam logic [SRC_MODE_W-1:0] SRC_ABS    = 3'd6;

  // destination codes
  localparam logic [DST_MODE_W-1:0] DST_REG = 2'd0;
  localparam logic [DST_MODE_W-1:0] DST_IND = 2'd1;
  localparam logic [DST_MODE_W-1:0] DST_IDX = 2'd2;
  localparam logic [DST_MODE_W-1:0] DST_ABS = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture modes, clear counters
    logic tickCycle;  // one more bus cycle spent
    logic tickWord;   // one more instruction word fetched
  } seqStrobe_t;

  function automatic logic srcHasExt(input logic [SRC_MODE_W-1:0] m);
    return (m == SRC_IMM) || (m == SRC_IDX) || (m == SRC_SYM) || (m == SRC_ABS);
  endfunction

  function automatic logic srcIsIndexed(input logic [SRC_MODE_W-1:0] m);
    return (m == SRC_IDX) || (m == SRC_SYM) || (m == SRC_ABS);
  endfunction

  function automatic logic srcIsIndirect(input logic [SRC_MODE_W-1:0] m);
    return (m == SRC_IND) || (m == SRC_INDINC);
  endfunction

  function automatic logic dstIsIndexed(input logic [DST_MODE_W-1:0] m);
    return (m == DST_IDX) || (m == DST_ABS);
  endfunction

  function automatic logic dstIsIndirect(input logic [DST_MODE_W-1:0] m);
    return (m == DST_IND);
  endfunction

endpackage

// File: rtl/opnd_seq_cnt.sv
module opnd_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc) begin
      value <= value + W'(1);
    end
  end

endmodule

// File: rtl/opnd_seq_ctrl.sv
module opnd_seq_ctrl
  import opnd_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SRC_MODE_W-1:0] srcModeQ,
  input  logic [DST_MODE_W-1:0] dstModeQ,
  output phase_e                phaseQ,
  output logic                  lastPhase,
  output seqStrobe_t            strobe
);

  phase_e nextPhase;
  phase_e dstEntry;

  // first destination phase (or idle) once source work is over
  always_comb begin
    if (dstIsIndexed(dstModeQ)) begin
      dstEntry = PH_DST_EXT;
    end else if (dstIsIndirect(dstModeQ)) begin
      dstEntry = PH_WRITE_BACK;
    end else begin
      dstEntry = PH_IDLE;
    end
  end

  always_comb begin
    nextPhase = phaseQ;
    case (phaseQ)
      PH_IDLE: begin
        nextPhase = start ? PH_FETCH : PH_IDLE;
      end
      PH_FETCH: begin
        if (srcHasExt(srcModeQ)) begin
          nextPhase = PH_SRC_EXT;
        end else if (srcIsIndirect(srcModeQ)) begin
          nextPhase = PH_SRC_READ;
        end else begin
          nextPhase = dstEntry;
        end
      end
      PH_SRC_EXT: begin
        nextPhase = srcIsIndexed(srcModeQ) ? PH_SRC_READ : dstEntry;
      end
      PH_SRC_READ:   nextPhase = dstEntry;
      PH_DST_EXT:    nextPhase = PH_DST_READ;
      PH_DST_READ:   nextPhase = PH_WRITE_BACK;
      PH_WRITE_BACK: nextPhase = PH_IDLE;
      default:       nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= nextPhase;
    end
  end

  always_comb begin
    lastPhase        = (phaseQ != PH_IDLE) && (nextPhase == PH_IDLE);
    strobe.load      = (phaseQ == PH_IDLE) && start;
    strobe.tickCycle = (phaseQ != PH_IDLE);
    strobe.tickWord  = (phaseQ == PH_FETCH) || (phaseQ == PH_SRC_EXT) ||
                       (phaseQ == PH_DST_EXT);
  end

endmodule

// File: rtl/opnd_seq_dp.sv
module opnd_seq_dp
  import opnd_seq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seqStrobe_t            strobe,
  input  logic [SRC_MODE_W-1:0] srcModeIn,
  input  logic [DST_MODE_W-1:0] dstModeIn,
  output logic [SRC_MODE_W-1:0] srcModeQ,
  output logic [DST_MODE_W-1:0] dstModeQ,
  output logic [CNT_W-1:0]      cycleCount,
  output logic [LEN_W-1:0]      wordCount
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcModeQ <= SRC_REG;
      dstModeQ <= DST_REG;
    end else if (strobe.load) begin
      srcModeQ <= srcModeIn;
      dstModeQ <= dstModeIn;
    end
  end

  opnd_seq_cnt #(.W(CNT_W)) cycleCnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (strobe.load),
    .inc   (strobe.tickCycle),
    .value (cycleCount)
  );

  opnd_seq_cnt #(.W(LEN_W)) wordCnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (strobe.load),
    .inc   (strobe.tickWord),
    .value (wordCount)
  );

endmodule

// File: rtl/opnd_seq_top.sv
module opnd_seq_top
  import opnd_seq_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_CYCLES + 1) + 1,
  parameter int LEN_W = $clog2(MAX_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SRC_MODE_W-1:0] srcMode,
  input  logic [DST_MODE_W-1:0] dstMode,
  output logic                  busy,
  output logic [2:0]            phase,
  output logic                  done,
  output logic [CNT_W-1:0]      cycleCount,
  output logic [LEN_W-1:0]      wordCount
);

  seqStrobe_t                strobe;
  phase_e                    phaseQ;
  logic [SRC_MODE_W-1:0]     srcModeQ;
  logic [DST_MODE_W-1:0]     dstModeQ;

  opnd_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .srcModeQ  (srcModeQ),
    .dstModeQ  (dstModeQ),
    .phaseQ    (phaseQ),
    .lastPhase (done),
    .strobe    (strobe)
  );

  opnd_seq_dp #(.CNT_W(CNT_W), .LEN_W(LEN_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .srcModeIn  (srcMode),
    .dstModeIn  (dstMode),
    .srcModeQ   (srcModeQ),
    .dstModeQ   (dstModeQ),
    .cycleCount (cycleCount),
    .wordCount  (wordCount)
  );

  assign phase = phaseQ;
  assign busy  = (phaseQ != PH_IDLE);

endmodule

// File: rtl/opnd_seq_chk.sv
module opnd_seq_chk #(
  parameter int CNT_W = 4,
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [2:0]       phase,
  input logic             done,
  input logic [CNT_W-1:0] cycleCount,
  input logic [LEN_W-1:0] wordCount
);

  assert_idle_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (phase == 3'd1) && (cycleCount == '0) && (wordCount == '0));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (phase != 3'd1));

  assert_done_in_sequence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_dst_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> (phase == 3'd5));

  assert_dst_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) |=> (phase == 3'd6));

  assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd7);

  assert_cycle_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cycleCount == CNT_W'($past(cycleCount) + 1'b1));

  assert_totals_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cycleCount) && $stable(wordCount));

  assert_fetch_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |=> wordCount == LEN_W'($past(wordCount) + 1'b1));

endmodule

bind opnd_seq_top opnd_seq_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .phase      (phase),
  .done       (done),
  .cycleCount (cycleCount),
  .wordCount  (wordCount)
);

// File: tb/opnd_seq_top_tb_top.sv
module opnd_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int LEN_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       srcMode = 3'd0;
  logic [1:0]       dstMode = 2'd0;
  logic             busy;
  logic [2:0]       phase;
  logic             done;
  logic [CNT_W-1:0] cycleCount;
  logic [LEN_W-1:0] wordCount;

  int checks = 0;
  int failures = 0;
  int expSeq [0:7];
  int expLen = 0;
  int expWords = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  opnd_seq_top #(.CNT_W(CNT_W), .LEN_W(LEN_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .srcMode    (srcMode),
    .dstMode    (dstMode),
    .busy       (busy),
    .phase      (phase),
    .done       (done),
    .cycleCount (cycleCount),
    .wordCount  (wordCount)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushPhase(input int p);
    expSeq[expLen] = p;
    expLen++;
  endtask

  // expected phase trail from R3, R4, R5; expected length from R8
  task automatic buildExp(input int s, input int d);
    expLen = 0;
    pushPhase(1);
    if (s == 3) begin
      pushPhase(2);
    end else if (s >= 4 && s <= 6) begin
      pushPhase(2);
      pushPhase(3);
    end else if (s == 1 || s == 2) begin
      pushPhase(3);
    end
    if (d == 1) begin
      pushPhase(6);
    end else if (d >= 2) begin
      pushPhase(4);
      pushPhase(5);
      pushPhase(6);
    end
    expWords = 1 + ((s >= 3 && s <= 6) ? 1 : 0) + ((d >= 2) ? 1 : 0);
  endtask

  // runs one sequence; glitchAt >= 0 drives a start pulse during that phase index
  task automatic runCase(input int s, input int d, input int litCycles,
                         input int litWords, input int glitchAt);
    buildExp(s, d);
    @(negedge clk);
    srcMode = 3'(s);
    dstMode = 2'(d);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    srcMode = ~3'(s);   // R2: captured modes must win
    dstMode = ~2'(d);
    for (int k = 0; k < expLen; k++) begin
      checkEq($sformatf("R5 phase s=%0d d=%0d k=%0d", s, d, k), int'(phase), expSeq[k]);
      checkEq($sformatf("R6 done s=%0d d=%0d k=%0d", s, d, k), int'(done),
              (k == expLen - 1) ? 1 : 0);
      if (k == 0) checkEq($sformatf("R2 busy s=%0d d=%0d", s, d), int'(busy), 1);
      if (k == glitchAt) begin
        start   = 1'b1;
        srcMode = 3'd0;
        dstMode = 2'd0;
      end
      @(negedge clk);
      start = 1'b0;
    end
    checkEq($sformatf("R9 idle after s=%0d d=%0d", s, d), int'(busy), 0);
    checkEq($sformatf("R7 cycles s=%0d d=%0d", s, d), int'(cycleCount), expLen);
    checkEq($sformatf("R8 words s=%0d d=%0d", s, d), int'(wordCount), expWords);
    if (litCycles > 0) begin
      checkEq($sformatf("R10 cycles s=%0d d=%0d", s, d), int'(cycleCount), litCycles);
      checkEq($sformatf("R10 words s=%0d d=%0d", s, d), int'(wordCount), litWords);
    end
    @(negedge clk);
    checkEq($sformatf("R7 hold cycles s=%0d d=%0d", s, d), int'(cycleCount), expLen);
    checkEq($sformatf("R9 no restart s=%0d d=%0d", s, d), int'(phase), 0);
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1 phase", int'(phase), 0);
    checkEq("R1 busy", int'(busy), 0);
    checkEq("R1 done", int'(done), 0);
    checkEq("R1 cycleCount", int'(cycleCount), 0);
    checkEq("R1 wordCount", int'(wordCount), 0);
  endtask

  task automatic testStatedExamples();  // R10
    runCase(0, 0, 1, 1, -1);
    runCase(0, 1, 2, 1, -1);
    runCase(0, 2, 4, 2, -1);
    runCase(3, 2, 5, 3, -1);
    runCase(6, 3, 6, 3, -1);
  endtask

  task automatic testAllModes();  // R3 R4 R8, reserved code 7 included
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 4; d++) begin
        runCase(s, d, 0, 0, -1);
      end
    end
  endtask

  task automatic testStartWhileBusy();  // R9
    runCase(6, 3, 6, 3, 2);
    runCase(6, 3, 6, 3, 5);   // pulse in the done cycle
    runCase(4, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testStatedExamples();
    testAllModes();
    testStartWhileBusy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule